// File: doc/BRIEF.md
# Hex-Base Floating-Point Multiplier

This block multiplies two 32-bit floating-point words in a base-16 format. Each word carries a sign, a 7-bit exponent stored with an offset of 64, and a 24-bit fraction made of six hexadecimal digits. A nonzero operand is expected to be normalized, so its fraction lies in [1/16, 1). The sign of the result comes from the two operand signs. The exponents are summed and the offset is removed once. The fractions are multiplied one hex digit of the multiplier per cycle. The product is then normalized by at most one digit and truncated to six digits.

A caller drives both words and raises a one-cycle start while the block reports ready. Seven clock edges after the accepting edge, a single-cycle done pulse appears. The result word and the two range flags stay unchanged from that pulse until the next accepted operation finishes. If the exponent of the result is too large, the result saturates to the largest magnitude and carries the computed sign. If the exponent is too small, the result becomes the zero word and the underflow flag is raised, so the surrounding computation can carry on.

Top module: `fpm16_mul`

## Requirements
- R1: Word layout: bit 31 is the sign (1 = negative), bits 30:24 are the exponent code (true exponent = code − 64), and bits 23:0 are the fraction, with bit 23 weighted 1/2. For a nonzero, non-saturated result, the result sign is the XOR of the two operand signs.
- R2: If the leading hex digit (bits 47:44) of the 48-bit fraction product is nonzero, the result exponent code equals code_a + code_b − 64, provided it stays in range.
- R3: If that leading product digit is zero, the product is moved up by one hex digit (4 bits) and the exponent code becomes code_a + code_b − 65. A nonzero in-range result from normalized operands therefore always has a nonzero leading fraction digit (bits 23:20).
- R4: The result fraction is the upper 24 bits of the normalized 48-bit product. Lower bits are dropped without rounding.
- R5: If the normalized exponent code exceeds 127 (true exponent above +63), the overflow flag is 1. The result is then the computed sign, exponent code 127 and fraction 0xFFFFFF.
- R6: If the normalized exponent code is below 0 (true exponent below −64), the underflow flag is 1 and the result is the all-zero word.
- R7: If either operand fraction is zero, the result is the all-zero word and both flags are 0, whatever the exponents and signs are.
- R8: Ready is 1 exactly when the block is idle. A start seen with ready at 1 is accepted. A start seen while busy has no effect. Done is a one-cycle pulse at the seventh rising edge after the accepting edge, and the result and flags change only on that edge.
- R9: After reset, ready is 1, done is 0, the result is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply |
| op_a_i | input | 32 | Multiplicand word |
| op_b_i | input | 32 | Multiplier word |
| ready_o | output | 1 | Idle, a start will be accepted |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| result_o | output | 32 | Product word |
| ovf_o | output | 1 | Exponent overflow of the last result |
| unf_o | output | 1 | Exponent underflow of the last result |

## Verification
Each result is due exactly seven rising edges after the edge that accepts the start. Ready drops right after that accepting edge. The bench drives inputs on falling edges and samples on falling edges. It confirms that done stays low in the six samples that follow the accept sample and is high in the seventh, and only there does it compare sign, exponent, fraction and flags against its own arithmetic model. One sample later it confirms that done has fallen while the result and flags hold. A start pulsed in the middle of an operation, with different operands, must leave that operation's result unchanged.

// File: rtl/fpm16_pkg.sv
package fpm16_pkg;
    parameter int EXP_W       = 7;
    parameter int DIGIT_W     = 4;
    parameter int FRAC_DIGITS = 6;

    localparam int FRAC_W = DIGIT_W * FRAC_DIGITS;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int PROD_W = 2 * FRAC_W;
    localparam int BIAS   = 1 << (EXP_W - 1);
    localparam int CNT_W  = $clog2(FRAC_DIGITS + 1);
    localparam int XW     = EXP_W + 2;

    typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_FIN} state_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fpw_t;

    typedef struct packed {
        state_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [PROD_W-1:0]  acc;
        logic [PROD_W-1:0]  mcand;
        logic [FRAC_W-1:0]  mplier;
        logic               sign;
        logic [EXP_W-1:0]   ea;
        logic [EXP_W-1:0]   eb;
        logic               zero;
        fpw_t               res;
        logic               ovf;
        logic               unf;
        logic               done;
    } regs_t;
endpackage

// File: rtl/fpm16_unpack.sv
module fpm16_unpack
    import fpm16_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fpw_t              fields_o,
    output logic              zero_o
);
    always_comb begin
        fields_o.sign = word_i[WORD_W-1];
        fields_o.exp  = word_i[WORD_W-2 -: EXP_W];
        fields_o.frac = word_i[FRAC_W-1:0];
        zero_o        = (word_i[FRAC_W-1:0] == '0);
    end
endmodule

// File: rtl/fpm16_digit_mac.sv
module fpm16_digit_mac
    import fpm16_pkg::*;
(
    input  logic [PROD_W-1:0]  acc_i,
    input  logic [PROD_W-1:0]  mcand_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [PROD_W-1:0]  acc_o
);
    // One partial product per bit of the current multiplier digit.
    logic [PROD_W-1:0] term [DIGIT_W];

    for (genvar b = 0; b < DIGIT_W; b++) begin : g_pp
        assign term[b] = digit_i[b] ? (mcand_i << b) : '0;
    end

    always_comb begin
        acc_o = acc_i;
        for (int b = 0; b < DIGIT_W; b++) begin
            acc_o = acc_o + term[b];
        end
    end
endmodule

// File: rtl/fpm16_normalize.sv
module fpm16_normalize
    import fpm16_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  ea_i,
    input  logic [EXP_W-1:0]  eb_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic              zero_i,
    output fpw_t              res_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);
    localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 1);

    logic                     shift;
    logic signed [XW-1:0]     esum;
    logic signed [XW-1:0]     ebiased;
    logic [FRAC_W-1:0]        frac_n;

    always_comb begin
        // A leading zero digit needs one hex-digit move up.
        shift   = (prod_i[PROD_W-1 -: DIGIT_W] == '0);
        frac_n  = shift ? prod_i[PROD_W-DIGIT_W-1 -: FRAC_W]
                        : prod_i[PROD_W-1 -: FRAC_W];
        esum    = $signed({2'b00, ea_i}) + $signed({2'b00, eb_i});
        // Remove the offset once; the constant touches only the bit EXP_W-1
        // column plus the borrow into the guard bits.
        ebiased = esum - BIAS_X - $signed({{(XW-1){1'b0}}, shift});

        res_o = '0;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (zero_i) begin
            res_o = '0;
        end else if (ebiased > EMAX_X) begin
            ovf_o      = 1'b1;
            res_o.sign = sign_i;
            res_o.exp  = '1;
            res_o.frac = '1;
        end else if (ebiased[XW-1]) begin
            unf_o = 1'b1;
            res_o = '0;
        end else begin
            res_o.sign = sign_i;
            res_o.exp  = ebiased[EXP_W-1:0];
            res_o.frac = frac_n;
        end
    end
endmodule

// File: rtl/fpm16_mul.sv
module fpm16_mul
    import fpm16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] op_a_i,
    input  logic [WORD_W-1:0] op_b_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic              ovf_o,
    output logic              unf_o
);
    regs_t q, d;

    fpw_t              fa, fb;
    logic              za, zb;
    logic [PROD_W-1:0] mac_out;
    fpw_t              norm_res;
    logic              norm_ovf, norm_unf;

    fpm16_unpack u_unp_a (.word_i(op_a_i), .fields_o(fa), .zero_o(za));
    fpm16_unpack u_unp_b (.word_i(op_b_i), .fields_o(fb), .zero_o(zb));

    fpm16_digit_mac u_mac (
        .acc_i   (q.acc),
        .mcand_i (q.mcand),
        .digit_i (q.mplier[DIGIT_W-1:0]),
        .acc_o   (mac_out)
    );

    fpm16_normalize u_norm (
        .sign_i (q.sign),
        .ea_i   (q.ea),
        .eb_i   (q.eb),
        .prod_i (q.acc),
        .zero_i (q.zero),
        .res_o  (norm_res),
        .ovf_o  (norm_ovf),
        .unf_o  (norm_unf)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_MUL;
                    d.cnt    = '0;
                    d.acc    = '0;
                    d.mcand  = {{(PROD_W-FRAC_W){1'b0}}, fa.frac};
                    d.mplier = fb.frac;
                    d.sign   = fa.sign ^ fb.sign;
                    d.ea     = fa.exp;
                    d.eb     = fb.exp;
                    d.zero   = za | zb;
                end
            end
            ST_MUL: begin
                d.acc    = mac_out;
                d.mcand  = q.mcand << DIGIT_W;
                d.mplier = q.mplier >> DIGIT_W;
                d.cnt    = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(FRAC_DIGITS - 1)) begin
                    d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                d.res  = norm_res;
                d.ovf  = norm_ovf;
                d.unf  = norm_unf;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ready_o  = (q.st == ST_IDLE);
    assign done_o   = q.done;
    assign result_o = q.res;
    assign ovf_o    = q.ovf;
    assign unf_o    = q.unf;
endmodule

// File: rtl/fpm16_chk.sv
module fpm16_chk
    import fpm16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ready_o,
    input logic              done_o,
    input logic [WORD_W-1:0] result_o,
    input logic              ovf_o,
    input logic              unf_o
);
    // R8: done lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the pulse is reported with the block idle again
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o);

    // R8: result and flags move only with done
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovf_o) && $stable(unf_o)));

    // R5 and R6: the two range flags never coincide
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    // R5: saturated magnitude on overflow
    a_r5_ovf_sat: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o[WORD_W-2:0] == '1));

    // R6: zero word on underflow
    a_r6_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (result_o == '0));

    // R3: in-range nonzero results have a nonzero leading digit
    a_r3_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o && (result_o[FRAC_W-1:0] != '0))
            |-> (result_o[FRAC_W-1 -: DIGIT_W] != '0));
endmodule

bind fpm16_mul fpm16_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
);

// File: tb/fpm16_mul_test.sv
module fpm16_mul_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        ready_o, done_o, ovf_o, unf_o;
    logic [31:0] result_o;

    int tests = 0;
    int fails = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm16_mul uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .ready_o(ready_o), .done_o(done_o), .result_o(result_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [33:0] act, input logic [33:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Returns {ovf, unf, word}; cat: 0 normal, 1 shifted, 2 ovf, 3 unf, 4 zero
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                          output int cat);
        logic [47:0] p;
        int          e;
        logic        s;
        s = a[31] ^ b[31];
        if (a[23:0] == 0 || b[23:0] == 0) begin
            cat = 4;
            return '0;
        end
        p = {24'd0, a[23:0]} * {24'd0, b[23:0]};
        e = int'(a[30:24]) + int'(b[30:24]) - 64;
        cat = 0;
        if (p[47:44] == 0) begin
            p = p << 4;
            e = e - 1;
            cat = 1;
        end
        if (e > 127) begin
            cat = 2;
            return {2'b10, s, 7'h7f, 24'hff_ffff};
        end
        if (e < 0) begin
            cat = 3;
            return {2'b01, 32'd0};
        end
        return {2'b00, s, e[6:0], p[47:24]};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit poke);
        logic [33:0] exp_v, act_v;
        int          cat;
        bit          early;
        string       tag;
        exp_v = model(a, b, cat);
        @(negedge clk);
        op_a_i  = a;
        op_b_i  = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(ready_o == 1'b0, "R8", "ready after accept", {33'd0, ready_o}, 34'd0);
        early = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            if (poke && i == 2) begin
                start_i = 1'b1;
                op_a_i  = ~a;
                op_b_i  = b ^ 32'h00AB_CDEF;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) early = 1'b1;
        end
        check(!early, "R8", "done before seventh edge", {33'd0, early}, 34'd0);
        @(negedge clk);
        check(done_o == 1'b1, "R8", "done at seventh edge", {33'd0, done_o}, 34'd1);
        act_v = {ovf_o, unf_o, result_o};
        case (cat)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R5";
            3: tag = "R6";
            default: tag = "R7";
        endcase
        check(act_v == exp_v, tag, poke ? "result with busy start (R8)" : "result",
              act_v, exp_v);
        if (cat <= 1) begin
            check(result_o[31] == exp_v[31], "R1", "sign",
                  {33'd0, result_o[31]}, {33'd0, exp_v[31]});
            check(result_o[23:0] == exp_v[23:0], "R4", "fraction",
                  {10'd0, result_o[23:0]}, {10'd0, exp_v[23:0]});
        end
        @(negedge clk);
        check(!done_o && {ovf_o, unf_o, result_o} == act_v, "R8", "pulse end and hold",
              {done_o, unf_o, result_o}, {1'b0, exp_v[32:0]});
    endtask

    function automatic logic [23:0] rand_frac();
        logic [31:0] r;
        r = next_rand();
        return {(r[27:24] == 0) ? 4'h1 : r[27:24], r[19:0]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(ready_o && !done_o && result_o == 0 && !ovf_o && !unf_o, "R9", "in reset",
              {ready_o, done_o, result_o}, {2'b10, 32'd0});
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o && !done_o && result_o == 0 && !ovf_o && !unf_o, "R9", "after reset",
              {ready_o, done_o, result_o}, {2'b10, 32'd0});

        // Exponent sweep with pseudo-random normalized fractions
        for (int i = 0; i < 44; i++) begin
            for (int j = 0; j < 44; j++) begin
                logic [6:0] ea, eb;
                logic [31:0] r;
                ea = (i == 43) ? 7'd127 : 7'(i * 3);
                eb = (j == 43) ? 7'd127 : 7'(j * 3);
                r  = next_rand();
                run_op({r[0], ea, rand_frac()}, {r[1], eb, rand_frac()}, 1'b0);
            end
        end

        // Leading-digit sweep, three low-bit patterns each (R3, R4)
        for (int da = 1; da < 16; da++) begin
            for (int db = 1; db < 16; db++) begin
                run_op({1'b0, 7'd64, 4'(da), 20'h00000}, {1'b1, 7'd64, 4'(db), 20'h00000}, 1'b0);
                run_op({1'b1, 7'd70, 4'(da), 20'hFFFFF}, {1'b1, 7'd60, 4'(db), 20'hFFFFF}, 1'b0);
                run_op({1'b0, 7'd50, 4'(da), rand_frac()[19:0]},
                       {1'b1, 7'd80, 4'(db), rand_frac()[19:0]}, 1'b0);
            end
        end

        // Range edges: R2 top code, R5 just over, R3 shift to code 0, R6 just under
        run_op({1'b0, 7'd127, 24'h800000}, {1'b1, 7'd64, 24'h200000}, 1'b0);
        run_op({1'b1, 7'd127, 24'h800000}, {1'b0, 7'd65, 24'h200000}, 1'b0);
        run_op({1'b0, 7'd1,   24'h100000}, {1'b0, 7'd64, 24'h100000}, 1'b0);
        run_op({1'b0, 7'd0,   24'h100000}, {1'b0, 7'd64, 24'h100000}, 1'b0);
        run_op({1'b0, 7'd0,   24'hF00000}, {1'b1, 7'd63, 24'h100000}, 1'b0);
        // R7: zero fraction beats huge or tiny exponents and signs
        run_op({1'b1, 7'd127, 24'h000000}, {1'b0, 7'd127, 24'hFFFFFF}, 1'b0);
        run_op({1'b0, 7'd3,   24'hABCDEF}, {1'b1, 7'd0,   24'h000000}, 1'b0);
        // R8: start while busy is ignored
        run_op({1'b1, 7'd66, 24'h123456}, {1'b0, 7'd62, 24'h9ABCDE}, 1'b1);
        run_op({1'b0, 7'd90, 24'hFFFFFF}, {1'b0, 7'd99, 24'hFFFFFF}, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule